// File: doc/BRIEF.md
# Time-Multiplexed Second-Order IIR Lowpass Filter

This block is a single-channel second-order lowpass IIR filter in direct form II. It takes one 16-bit signed sample every ten clock cycles and returns one filtered sample per period. All nine arithmetic steps of a sample run on two shared units: a three-stage constant multiplier and a four-stage adder. A fixed cyclic schedule drives both. The work for one sample spans two consecutive periods and overlaps with the work for the next sample.

A phase counter steps from 0 to 9. It selects the multiplier operand and coefficient, the adder operands, and the write and read slots of a two-entry storage element that has one read port and one write port. Values used in the same cycle they appear go straight from one unit to the next. Values that must wait go through the storage element. Two state registers hold the past values of the intermediate node.

Top module: `iir2_tdm`

## Requirements
- R1: For each period the block computes w = x + b1·s1 + b2·s2 and y = a0·w + a1·s1 + a2·s2. It then moves s1 into s2 and w into s1. All values are 16-bit two's complement.
- R2: The coefficients are signed constants with 9 fractional bits: a0 = 114, a1 = 220, a2 = 114, b1 = 179 and b2 = −171, each in units of 1/512.
- R3: Each product is the full product shifted right arithmetically by 9 bits (rounding toward minus infinity) and cut to its low 16 bits. Every sum wraps modulo 2^16.
- R4: The period is 10 cycles. Phase 0 is the first cycle with reset low, and it recurs every 10 cycles. A sample is taken only in phase 0. The values of in_valid and in_data in phases 1 to 9 have no effect on any output.
- R5: If in_valid is low in phase 0, that period uses x = 0. The state still advances, but no output pulse is produced for that period.
- R6: A sample taken in phase 0 of cycle T produces a one-cycle out_valid pulse in cycle T + 20, which is again phase 0. out_data holds its value in every cycle where out_valid is low.
- R7: Synchronous active-high reset clears the state registers, the storage element, the unit pipelines, out_valid and out_data. out_valid stays low until the result of the first sample taken after reset.
- R8: The adder starts an operation at most every other cycle, so each addition has two cycles to itself. The multiplier may start an operation every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks in_data as a sample; only looked at in phase 0 |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | One-cycle pulse when out_data carries a new result |
| out_data | output | 16 | Signed filtered sample, held between pulses |

## Verification
The hardest case to reach from the ports is a skipped phase-0 slot while the previous sample is still in flight. In that case the state must advance with a zero input, the overlapping output of the earlier sample must still appear, and the pulse for the skipped slot must not. The stimulus table places an invalid slot between valid samples to create this case. A random section toggles in_valid and in_data in every non-zero phase to show that those cycles are ignored. A reset applied mid-period, with operations from two samples still in the unit pipelines, is followed by an impulse whose response must match a freshly cleared model.

// File: rtl/iir2_tdm.sv
`timescale 1ns/1ps
module iir2_tdm #(
  parameter int DW   = 16,
  parameter int CW   = 10,
  parameter int FRAC = 9,
  parameter int A0   = 114,
  parameter int A1   = 220,
  parameter int A2   = 114,
  parameter int B1   = 179,
  parameter int B2   = -171
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  localparam int PERIOD = 10;
  localparam int MLAT   = 3;
  localparam int ALAT   = 4;
  localparam int PW     = DW + CW;
  localparam logic signed [CW-1:0] K_A0 = CW'(A0);
  localparam logic signed [CW-1:0] K_A1 = CW'(A1);
  localparam logic signed [CW-1:0] K_A2 = CW'(A2);
  localparam logic signed [CW-1:0] K_B1 = CW'(B1);
  localparam logic signed [CW-1:0] K_B2 = CW'(B2);

  logic [3:0]           ph;
  logic signed [DW-1:0] s1, s2, x_r;
  logic                 tag0, tag1;
  logic signed [DW-1:0] mul_a, mul_q, add_x, add_y, add_q, mem_rd, mem_wd;
  logic signed [CW-1:0] coef;
  logic signed [PW-1:0] prod;
  logic                 add_go, mem_we, mem_wa, mem_ra;
  logic signed [DW-1:0] mp  [MLAT];
  logic signed [DW-1:0] ap  [ALAT];
  logic signed [DW-1:0] mem [2];
  logic                 unused_bits;

  always_ff @(posedge clk) begin
    if (rst || ph == 4'(PERIOD - 1)) ph <= 4'd0;
    else                             ph <= ph + 4'd1;
  end

  // multiplier slots: 0 b2*w[n-2], 2 a0*w[n-1], 4 b1*w[n-1], 5 a1*w[n-1], 6 a2*w[n-2]
  always_comb begin
    mul_a = '0;
    coef  = '0;
    case (ph)
      4'd0: begin mul_a = s1; coef = K_B2; end
      4'd2: begin mul_a = s1; coef = K_A0; end
      4'd4: begin mul_a = s1; coef = K_B1; end
      4'd5: begin mul_a = s1; coef = K_A1; end
      4'd6: begin mul_a = s2; coef = K_A2; end
      default: ;
    endcase
  end

  assign prod        = PW'(mul_a) * PW'(coef);
  assign unused_bits = ^{prod[FRAC-1:0], prod[PW-1:FRAC+DW]};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MLAT; i++) mp[i] <= '0;
    end else begin
      mp[0] <= prod[FRAC +: DW];
      for (int i = 1; i < MLAT; i++) mp[i] <= mp[i-1];
    end
  end
  assign mul_q = mp[MLAT-1];

  // adder slots: 3 x+p, 5 final sum of previous sample, 7 node w, 9 feedforward pair
  always_comb begin
    add_x  = '0;
    add_y  = '0;
    add_go = 1'b0;
    case (ph)
      4'd3: begin add_x = x_r;    add_y = mul_q; add_go = 1'b1; end
      4'd5: begin add_x = mem_rd; add_y = mul_q; add_go = 1'b1; end
      4'd7: begin add_x = add_q;  add_y = mul_q; add_go = 1'b1; end
      4'd9: begin add_x = mem_rd; add_y = mul_q; add_go = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ALAT; i++) ap[i] <= '0;
    end else begin
      ap[0] <= add_x + add_y;
      for (int i = 1; i < ALAT; i++) ap[i] <= ap[i-1];
    end
  end
  assign add_q = ap[ALAT-1];

  assign mem_we = (ph == 4'd8) || (ph == 4'd3);
  assign mem_wa = (ph == 4'd3);
  assign mem_wd = (ph == 4'd3) ? add_q : mul_q;
  assign mem_ra = (ph == 4'd5);
  assign mem_rd = mem[mem_ra];

  always_ff @(posedge clk) begin
    if (rst) begin
      mem[0] <= '0;
      mem[1] <= '0;
    end else if (mem_we) begin
      mem[mem_wa] <= mem_wd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1        <= '0;
      s2        <= '0;
      x_r       <= '0;
      tag0      <= 1'b0;
      tag1      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (ph == 4'd0) begin
        x_r  <= in_valid ? in_data : '0;
        tag0 <= in_valid;
      end
      if (ph == 4'd1) begin
        s1 <= add_q;
        s2 <= s1;
      end
      if (ph == 4'd9) begin
        tag1      <= tag0;
        out_valid <= tag1;
        if (tag1) out_data <= add_q;
      end
    end
  end
endmodule

// File: rtl/iir2_tdm_chk.sv
`timescale 1ns/1ps
module iir2_tdm_chk #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_data,
  input logic [3:0]           ph,
  input logic                 add_go,
  input logic signed [DW-1:0] s1,
  input logic signed [DW-1:0] s2
);
  assert_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  assert_phase_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ph == 4'd0);

  assert_adder_gap_R8: assert property (@(posedge clk) disable iff (rst)
    add_go |=> !add_go);

  assert_state_step_R1: assert property (@(posedge clk) disable iff (rst)
    ph != 4'd2 |-> ($stable(s1) && $stable(s2)));

  assert_rst_clear_R7: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));
endmodule

bind iir2_tdm iir2_tdm_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_data(out_data),
  .ph(ph), .add_go(add_go), .s1(s1), .s2(s2)
);

// File: tb/iir2_tdm_tb_top.sv
`timescale 1ns/1ps
module iir2_tdm_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic out_valid;
  logic signed [15:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int nsamp = 0;
  bit done = 1'b0;
  string sect = "R1";
  logic signed [15:0] ms1, ms2, last_out;
  logic signed [15:0] exp_y [256];
  logic               exp_v [256];

  // bit 16: valid, bits 15:0: sample
  localparam logic [16:0] STIM [24] = '{
    17'h1_4000, 17'h1_0000, 17'h1_0000, 17'h1_0000, 17'h1_0000, 17'h1_0000,
    17'h1_2000, 17'h1_2000, 17'h1_2000, 17'h1_2000, 17'h1_2000, 17'h1_2000,
    17'h0_1234, 17'h1_2000, 17'h0_0000,
    17'h1_7FFF, 17'h1_7FFF, 17'h1_8000, 17'h1_8000, 17'h1_7FFF, 17'h1_8000,
    17'h1_FFFF, 17'h1_0000, 17'h1_0000
  };

  iir2_tdm dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic logic signed [15:0] fmul(input logic signed [15:0] d, input int c);
    longint p;
    p = longint'(d) * longint'(c);
    p = p >>> 9;
    return p[15:0];
  endfunction

  task automatic model_step(input logic v, input logic signed [15:0] d);
    logic signed [15:0] x, w, y;
    x = v ? d : 16'sd0;
    w = x + fmul(ms1, 179) + fmul(ms2, -171);
    y = fmul(w, 114) + fmul(ms1, 220) + fmul(ms2, 114);
    exp_y[nsamp] = y;
    exp_v[nsamp] = v;
    ms2 = ms1;
    ms1 = w;
    nsamp++;
  endtask

  task automatic check_outputs();
    if (cyc % 10 == 0 && cyc >= 20) begin
      int k;
      k = cyc / 10 - 2;
      chk(out_valid == exp_v[k], exp_v[k] ? "R6" : "R5", int'(out_valid), int'(exp_v[k]));
      if (exp_v[k]) begin
        chk(out_data == exp_y[k], sect, int'(out_data), int'(exp_y[k]));
        last_out = exp_y[k];
      end
    end else begin
      chk(out_valid == 1'b0, (cyc < 20) ? "R7" : "R6", int'(out_valid), 0);
      chk(out_data == last_out, "R6", int'(out_data), int'(last_out));
    end
  endtask

  task automatic run_sample(input logic v, input logic signed [15:0] d, input bit noise);
    for (int i = 0; i < 10; i++) begin
      check_outputs();
      if (i == 0) begin
        in_valid = v;
        in_data  = d;
        model_step(v, d);
      end else begin
        in_valid = noise ? 1'($urandom) : 1'b0;
        in_data  = noise ? 16'($urandom) : 16'sd0;
      end
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic do_reset(input int hold);
    rst = 1'b1;
    in_valid = 1'b0;
    for (int i = 0; i < hold; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
    chk(out_valid == 1'b0, "R7", int'(out_valid), 0);
    chk(out_data == 16'sd0, "R7", int'(out_data), 0);
    rst = 1'b0;
    cyc = 0;
    nsamp = 0;
    ms1 = '0;
    ms2 = '0;
    last_out = '0;
  endtask

  initial begin
    @(negedge clk);
    do_reset(3);

    // table walk
    for (int i = 0; i < 24; i++) begin
      if (i < 6)       sect = "R2";
      else if (i < 12) sect = "R1";
      else if (i < 15) sect = "R5";
      else if (i < 21) sect = "R3";
      else             sect = "R1";
      run_sample(STIM[i][16], STIM[i][15:0], 1'b0);
    end

    // random samples with activity on inputs in every non-zero phase (R4)
    sect = "R4";
    for (int i = 0; i < 60; i++)
      run_sample(($urandom % 8) != 0, 16'($urandom), 1'b1);
    run_sample(1'b0, 16'sd0, 1'b0);
    run_sample(1'b0, 16'sd0, 1'b0);

    // reset in mid period with two samples in flight (R7)
    run_sample(1'b1, 16'sd12000, 1'b0);
    run_sample(1'b1, -16'sd9000, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
    do_reset(2);
    sect = "R7";
    run_sample(1'b1, 16'sd16384, 1'b0);
    for (int i = 0; i < 6; i++) run_sample(1'b0, 16'sd0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5 * 50000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule